// File: doc/BRIEF.md
# DMA Requester with Adaptive NACK Backoff

This block moves a memory transfer onto a packet bus on behalf of a device. A request gives a command (read or write), a start byte address and a byte length. The block cuts it into packets that each stay inside one aligned bus block. It queues the packets and offers them one at a time on a valid/ready request channel. Only one request is in flight at a time, and `busy` marks that window.

The bus can answer in three ways. First, it can refuse a packet at the moment it is offered: `pkt_valid` is high while `pkt_ready` is low. The block then goes quiet until a `retry` pulse arrives. Second, the target can return a negative acknowledgement. The block puts that packet back at the head of the queue and lengthens its backoff interval. Third, the target can return a good response. The block counts that packet's bytes and shortens the backoff interval. When the good responses add up to the request length, a one-cycle `done` pulse is raised and `busy` falls.

The backoff value sets the spacing between sends. At zero, packets go out back to back. When it is non-zero, a countdown timer separates each send from the next.

Top module: `dma_backoff_req`

## Requirements
- R1: A request of length L at address A is cut into packets in ascending address order. Each packet's size is the smaller of the bytes left and the distance from its address to the next multiple of BLK, so no packet crosses a BLK boundary.
- R2: Packets are offered in queue order, and `pkt_write` echoes the latched command (1 = write). While the backoff value is zero, queued packets are accepted in consecutive cycles.
- R3: A NACK arriving while the backoff value is below `min_backoff` sets the backoff value to `min_backoff`.
- R4: A NACK arriving while the backoff value is at least `min_backoff` and below `max_backoff` doubles the value, capped at `max_backoff`. A NACK arriving at `max_backoff` leaves it unchanged.
- R5: A NACKed packet (`rsp_addr`, `rsp_size`) is placed at the head of the queue, ahead of packets not yet sent. The countdown timer is reloaded with the updated backoff value B, so the next send is accepted exactly B+1 cycles after the NACK cycle.
- R6: Each good response shifts the backoff value right by two bits.
- R7: A cycle with `pkt_valid` high and `pkt_ready` low is a refusal. After a refusal, `pkt_valid` stays low until a `retry` pulse. The same head packet is offered again in the cycle after that pulse.
- R8: With a non-zero backoff value B, an accepted send that leaves further packets pending is followed by the next send exactly B+1 cycles later.
- R9: Good responses add `rsp_size` to a byte count. In the cycle after the response that makes the count equal to the request length, `done` is high for one cycle and `busy` falls. `done` never fires earlier, and the count never exceeds the length.
- R10: `busy` rises in the cycle after a request is taken. A request presented while `busy` is high, or one with length zero, is ignored and produces no packets.
- R11: After reset, `busy`, `pkt_valid` and `done` are low and the backoff value is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe |
| req_write | input | 1 | Request command, 1 = write, 0 = read |
| req_addr | input | AW | Request start byte address |
| req_len | input | LW | Request length in bytes |
| busy | output | 1 | High from request accept until its completion pulse |
| min_backoff | input | BW | Backoff floor in cycles |
| max_backoff | input | BW | Backoff ceiling in cycles |
| pkt_valid | output | 1 | Packet offered on the bus |
| pkt_ready | input | 1 | Bus takes the offered packet; low while valid means refusal |
| pkt_write | output | 1 | Command of the offered packet |
| pkt_addr | output | AW | Start address of the offered packet |
| pkt_size | output | $clog2(BLK)+1 | Byte count of the offered packet |
| retry | input | 1 | Bus invites a resend after a refusal |
| rsp_valid | input | 1 | Response strobe |
| rsp_nack | input | 1 | Response is a negative acknowledgement |
| rsp_addr | input | AW | Address of the responded packet |
| rsp_size | input | $clog2(BLK)+1 | Size of the responded packet |
| done | output | 1 | One-cycle pulse when every byte has been acknowledged |

## Verification
The bench builds the block with a 16-byte block size, an 8-bit length, a 16-bit address and a 6-bit backoff. The floor and ceiling are driven to 4 and 16 cycles during the backoff phases. With these values, a short series of NACKs walks the backoff through the floor, two doublings and the ceiling, and one good response brings it back down. Each step shows up as a measurable gap of 5, 9 or 17 cycles. The 16-byte block lets both aligned and misaligned requests of a few dozen bytes produce short and full packets at block edges. A request of three packets, with the backoff non-zero and an early NACK, exercises head-of-queue reinsertion while later packets are still waiting.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_GOOD = 2'd1,
    RSP_NACK = 2'd2
  } rsp_kind_e;

  function automatic rsp_kind_e classify_rsp(input logic valid, input logic nack);
    if (!valid)
      return RSP_NONE;
    else if (nack)
      return RSP_NACK;
    else
      return RSP_GOOD;
  endfunction

endpackage

// File: rtl/dbr_chunker.sv
module dbr_chunker #(
  parameter int AW  = 32,
  parameter int LW  = 8,
  parameter int BLK = 16,
  localparam int OW = $clog2(BLK),
  localparam int SW = OW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic          stall,
  output logic          push,
  output logic [AW-1:0] pkt_addr,
  output logic [SW-1:0] pkt_size,
  output logic          active
);

  logic [AW-1:0] cur_addr;
  logic [LW-1:0] left;
  logic [SW-1:0] room;

  // bytes from the current address up to the next block edge
  assign room     = SW'(BLK) - {1'b0, cur_addr[OW-1:0]};
  assign pkt_size = (left < LW'(room)) ? left[SW-1:0] : room;
  assign pkt_addr = cur_addr;
  assign push     = active && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cur_addr <= '0;
      left     <= '0;
    end else if (start) begin
      active   <= 1'b1;
      cur_addr <= start_addr;
      left     <= start_len;
    end else if (push) begin
      cur_addr <= cur_addr + AW'(pkt_size);
      left     <= left - LW'(pkt_size);
      if (LW'(pkt_size) == left)
        active <= 1'b0;
    end
  end

  // R1: an emitted packet stays inside one block
  p_no_cross_r1: assert property (@(posedge clk) disable iff (rst)
    push |-> (({1'b0, pkt_addr[OW-1:0]} + pkt_size) <= SW'(BLK)) && (pkt_size != '0));

endmodule

// File: rtl/dbr_txq.sv
module dbr_txq #(
  parameter int AW    = 32,
  parameter int SW    = 5,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_back,
  input  logic          push_front,
  input  logic          pop,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_size,
  output logic [AW-1:0] head_addr,
  output logic [SW-1:0] head_size,
  output logic          empty,
  output logic [CW-1:0] count
);

  localparam int DW = AW + SW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head;
  logic [PW-1:0] tail;
  logic [PW-1:0] wptr;
  logic          wen;

  assign wen  = push_back || push_front;
  // a front insert lands just ahead of the head as it stands after a pop
  assign wptr = push_front ? (pop ? head : head - PW'(1)) : tail;

  always_ff @(posedge clk) begin
    if (wen)
      mem[wptr] <= {wr_addr, wr_size};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push_front && !pop)
        head <= head - PW'(1);
      else if (pop && !push_front)
        head <= head + PW'(1);
      if (push_back)
        tail <= tail + PW'(1);
      count <= count + CW'(wen) - CW'(pop);
    end
  end

  assign {head_addr, head_size} = mem[head];
  assign empty = (count == '0);

  // R5: a reinserted packet always finds a free slot
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (wen && !pop) |-> (count < CW'(DEPTH)));

  // R2: only a queued packet is ever taken
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/dbr_pacer.sv
module dbr_pacer #(
  parameter int BW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] min_bo,
  input  logic [BW-1:0] max_bo,
  input  logic          nack,
  input  logic          good,
  input  logic          accept,
  input  logic          refuse,
  input  logic          retry,
  input  logic          more,
  output logic          send_ok
);

  logic [BW-1:0] bo;
  logic [BW-1:0] timer;
  logic          retry_wait;
  logic [BW:0]   dbl;
  logic [BW-1:0] bo_after_nack;

  assign dbl = {bo, 1'b0};

  always_comb begin
    if (bo < min_bo)
      bo_after_nack = min_bo;
    else if (bo < max_bo)
      bo_after_nack = (dbl > {1'b0, max_bo}) ? max_bo : dbl[BW-1:0];
    else
      bo_after_nack = bo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bo         <= '0;
      timer      <= '0;
      retry_wait <= 1'b0;
    end else begin
      if (nack)
        bo <= bo_after_nack;
      else if (good)
        bo <= bo >> 2;

      if (nack)
        timer <= bo_after_nack;
      else if (accept && (bo != '0) && more)
        timer <= bo;
      else if (timer != '0)
        timer <= timer - BW'(1);

      if (refuse)
        retry_wait <= 1'b1;
      else if (retry)
        retry_wait <= 1'b0;
    end
  end

  assign send_ok = (timer == '0) && !retry_wait;

  // R3: a NACK below the floor lifts the backoff to the floor
  p_nack_min_r3: assert property (@(posedge clk) disable iff (rst)
    (nack && (bo < min_bo) && $stable(min_bo)) |=> (bo == $past(min_bo)));

  // R4: a NACK in the growth band never passes the ceiling
  p_nack_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (nack && (bo >= min_bo) && (bo <= max_bo)) |=> (bo <= $past(max_bo)) && (bo >= $past(bo)));

  // R6: a good response divides the backoff by four
  p_good_shrink_r6: assert property (@(posedge clk) disable iff (rst)
    (good && !nack) |=> (bo == ($past(bo) >> 2)));

  // R5: after a NACK the timer holds the fresh backoff value
  p_timer_load_r5: assert property (@(posedge clk) disable iff (rst)
    nack |=> (timer == bo));

  // R7: the retry wait persists until a retry pulse
  p_retry_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (retry_wait && !retry) |=> retry_wait);

endmodule

// File: rtl/dma_backoff_req.sv
module dma_backoff_req
  import dbr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 8,
  parameter int BLK = 16,
  parameter int BW  = 10,
  localparam int SW = $clog2(BLK) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          busy,
  input  logic [BW-1:0] min_backoff,
  input  logic [BW-1:0] max_backoff,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic          pkt_write,
  output logic [AW-1:0] pkt_addr,
  output logic [SW-1:0] pkt_size,
  input  logic          retry,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  input  logic [AW-1:0] rsp_addr,
  input  logic [SW-1:0] rsp_size,
  output logic          done
);

  // worst case: full-length request starting just below a block edge
  localparam int MAXP = ((2**LW - 1) + BLK - 1) / BLK + 1;
  localparam int QD   = 2**$clog2(MAXP);
  localparam int QCW  = $clog2(QD) + 1;

  rsp_kind_e     kind;
  logic          req_take;
  logic          nack_now;
  logic          good_now;
  logic          ch_push;
  logic          ch_active;
  logic [AW-1:0] ch_addr;
  logic [SW-1:0] ch_size;
  logic          q_empty;
  logic [QCW-1:0] q_count;
  logic          q_full;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_size;
  logic          send_ok;
  logic          accept;
  logic          refuse;
  logic          more;
  logic [LW-1:0] tot;
  logic [LW-1:0] got;
  logic [LW:0]   got_sum;

  assign kind     = classify_rsp(rsp_valid, rsp_nack);
  assign nack_now = (kind == RSP_NACK);
  assign good_now = (kind == RSP_GOOD);
  assign req_take = req_valid && !busy && (req_len != '0);
  assign q_full   = (q_count == QCW'(QD));

  dbr_chunker #(.AW(AW), .LW(LW), .BLK(BLK)) u_chunk (
    .clk        (clk),
    .rst        (rst),
    .start      (req_take),
    .start_addr (req_addr),
    .start_len  (req_len),
    .stall      (nack_now || q_full),
    .push       (ch_push),
    .pkt_addr   (ch_addr),
    .pkt_size   (ch_size),
    .active     (ch_active)
  );

  // one write port: a NACK reinsert takes it, the chunker waits that cycle
  assign wr_addr = nack_now ? rsp_addr : ch_addr;
  assign wr_size = nack_now ? rsp_size : ch_size;

  dbr_txq #(.AW(AW), .SW(SW), .DEPTH(QD)) u_txq (
    .clk        (clk),
    .rst        (rst),
    .push_back  (ch_push),
    .push_front (nack_now),
    .pop        (accept),
    .wr_addr    (wr_addr),
    .wr_size    (wr_size),
    .head_addr  (pkt_addr),
    .head_size  (pkt_size),
    .empty      (q_empty),
    .count      (q_count)
  );

  assign pkt_valid = !q_empty && send_ok;
  assign accept    = pkt_valid && pkt_ready;
  assign refuse    = pkt_valid && !pkt_ready;
  assign more      = (q_count > QCW'(1)) || ch_active;

  dbr_pacer #(.BW(BW)) u_pacer (
    .clk     (clk),
    .rst     (rst),
    .min_bo  (min_backoff),
    .max_bo  (max_backoff),
    .nack    (nack_now),
    .good    (good_now),
    .accept  (accept),
    .refuse  (refuse),
    .retry   (retry),
    .more    (more),
    .send_ok (send_ok)
  );

  assign got_sum = {1'b0, got} + (LW+1)'(rsp_size);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pkt_write <= 1'b0;
      tot       <= '0;
      got       <= '0;
    end else begin
      done <= 1'b0;
      if (req_take) begin
        busy      <= 1'b1;
        pkt_write <= req_write;
        tot       <= req_len;
        got       <= '0;
      end else if (good_now && busy) begin
        if (got_sum == {1'b0, tot}) begin
          done <= 1'b1;
          busy <= 1'b0;
          got  <= '0;
        end else begin
          got <= got_sum[LW-1:0];
        end
      end
    end
  end

  // R7: a refused offer is withdrawn in the following cycle
  p_refuse_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> !pkt_valid);

  // R9: completion only follows a good response
  p_done_after_good_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rsp_valid && !rsp_nack) && !busy);

  // R9: the byte count never runs past the request length
  p_got_bound_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (got <= tot));

  // R10: nothing is offered outside a request
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !rsp_valid) |-> !pkt_valid);

endmodule

// File: tb/dma_backoff_req_bench.sv
module dma_backoff_req_bench;

  localparam int AW  = 16;
  localparam int LW  = 8;
  localparam int BLK = 16;
  localparam int BW  = 6;
  localparam int SW  = 5;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [SW-1:0] s;
  } pk_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          busy;
  logic [BW-1:0] min_backoff;
  logic [BW-1:0] max_backoff;
  logic          pkt_valid;
  logic          pkt_ready;
  logic          pkt_write;
  logic [AW-1:0] pkt_addr;
  logic [SW-1:0] pkt_size;
  logic          retry;
  logic          rsp_valid;
  logic          rsp_nack;
  logic [AW-1:0] rsp_addr;
  logic [SW-1:0] rsp_size;
  logic          done;

  always #5 clk = ~clk;

  dma_backoff_req #(.AW(AW), .LW(LW), .BLK(BLK), .BW(BW)) u_dma_backoff_req (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy),
    .min_backoff(min_backoff), .max_backoff(max_backoff),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_write(pkt_write),
    .pkt_addr(pkt_addr), .pkt_size(pkt_size), .retry(retry),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_addr(rsp_addr),
    .rsp_size(rsp_size), .done(done)
  );

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  int   acc_n = 0;
  int   ref_n = 0;
  int   done_n = 0;
  int   mark_cyc = 0;
  int   acc_at [64];
  logic exp_w = 1'b0;
  pk_t  exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each accepted packet with the scoreboard head
  always @(negedge clk) begin
    if (!rst) begin
      if (pkt_valid && pkt_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 packet with no expected entry", longint'(pkt_addr), 0);
        end else begin
          pk_t e;
          e = exp_q.pop_front();
          check({pkt_addr, pkt_size} == e, "R1 packet address/size",
                longint'({pkt_addr, pkt_size}), longint'(e));
          check(pkt_write == exp_w, "R2 packet command", longint'(pkt_write), longint'(exp_w));
        end
        if (acc_n < 64) acc_at[acc_n] = cyc;
        acc_n++;
      end
      if (pkt_valid && !pkt_ready) ref_n++;
      if (done) done_n++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue(input bit w, input int a, input int l);
    int ad;
    int rem;
    ad  = a;
    rem = l;
    while (rem > 0) begin
      int room;
      int sz;
      pk_t p;
      room = BLK - (ad % BLK);
      sz   = (rem < room) ? rem : room;
      p.a  = AW'(ad);
      p.s  = SW'(sz);
      exp_q.push_back(p);
      ad  += sz;
      rem -= sz;
    end
    exp_w     = w;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = AW'(a);
    req_len   = LW'(l);
    tick(1);
    req_valid = 1'b0;
  endtask

  task automatic respond(input bit nk, input int a, input int s);
    if (nk) begin
      pk_t p;
      p.a = AW'(a);
      p.s = SW'(s);
      exp_q.push_front(p);
    end
    rsp_valid = 1'b1;
    rsp_nack  = nk;
    rsp_addr  = AW'(a);
    rsp_size  = SW'(s);
    mark_cyc  = cyc;
    tick(1);
    rsp_valid = 1'b0;
    rsp_nack  = 1'b0;
  endtask

  task automatic pulse_retry();
    retry    = 1'b1;
    mark_cyc = cyc;
    tick(1);
    retry = 1'b0;
  endtask

  task automatic wait_acc(input int n);
    int t;
    t = 0;
    while (acc_n < n && t < 2000) begin
      tick(1);
      t++;
    end
    check(acc_n >= n, "R2 expected send never accepted", acc_n, n);
  endtask

  initial begin
    #(10 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    min_backoff = '0; max_backoff = '0; pkt_ready = 1'b1; retry = 1'b0;
    rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_addr = '0; rsp_size = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(pkt_valid == 1'b0, "R11 pkt_valid after reset", pkt_valid, 0);
    check(done == 1'b0, "R11 done after reset", done, 0);

    // aligned write, zero backoff: back-to-back sends
    issue(1, 'h100, 40);
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    wait_acc(3);
    check(acc_at[2] - acc_at[0] == 2, "R2 back-to-back spacing", acc_at[2] - acc_at[0], 2);
    respond(0, 'h100, 16);
    respond(0, 'h110, 16);
    tick(1);
    check(done_n == 0, "R9 no early done", done_n, 0);
    respond(0, 'h120, 8);
    tick(1);
    check(done_n == 1, "R9 done after full count", done_n, 1);
    check(busy == 1'b0, "R9 busy falls at done", busy, 0);

    // misaligned start: short first and last packets
    issue(1, 'h107, 30);
    wait_acc(6);
    respond(0, 'h107, 9);
    respond(0, 'h110, 16);
    respond(0, 'h120, 5);
    tick(1);
    check(done_n == 2, "R9 done for misaligned request", done_n, 2);

    // refusal then retry
    pkt_ready = 1'b0;
    issue(0, 'h200, 16);
    tick(3);
    pkt_ready = 1'b1;
    tick(4);
    check(ref_n == 1, "R7 single refusal then quiet", ref_n, 1);
    check(acc_n == 6, "R7 no send before retry", acc_n, 6);
    pulse_retry();
    wait_acc(7);
    check(acc_at[6] == mark_cyc + 1, "R7 resend in cycle after retry", acc_at[6], mark_cyc + 1);
    respond(0, 'h200, 16);
    tick(1);
    check(done_n == 3, "R9 done after retried packet", done_n, 3);

    // backoff growth, ceiling and shrink
    min_backoff = BW'(4);
    max_backoff = BW'(16);
    issue(0, 'h300, 32);
    wait_acc(9);
    check(acc_at[8] - acc_at[7] == 1, "R2 back-to-back at zero backoff", acc_at[8] - acc_at[7], 1);
    respond(1, 'h300, 16);
    wait_acc(10);
    check(acc_at[9] - mark_cyc == 5, "R3 floor after NACK", acc_at[9] - mark_cyc, 5);
    respond(1, 'h310, 16);
    wait_acc(11);
    check(acc_at[10] - mark_cyc == 9, "R4 doubled backoff", acc_at[10] - mark_cyc, 9);
    respond(1, 'h300, 16);
    wait_acc(12);
    check(acc_at[11] - mark_cyc == 17, "R4 doubled to ceiling", acc_at[11] - mark_cyc, 17);
    respond(1, 'h310, 16);
    wait_acc(13);
    check(acc_at[12] - mark_cyc == 17, "R4 saturated at ceiling", acc_at[12] - mark_cyc, 17);
    respond(0, 'h300, 16);
    respond(1, 'h310, 16);
    wait_acc(14);
    check(acc_at[13] - mark_cyc == 9, "R6 shrink then double", acc_at[13] - mark_cyc, 9);
    respond(0, 'h310, 16);
    tick(1);
    check(done_n == 4, "R9 done after NACKed packets", done_n, 4);

    // backoff now 2: head reinsertion and paced sends, stray request while busy
    issue(1, 'h400, 48);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'('h900); req_len = LW'(16);
    tick(1);
    req_valid = 1'b0;
    wait_acc(15);
    respond(1, 'h400, 16);
    wait_acc(18);
    check(acc_at[15] - mark_cyc == 5, "R5 NACKed packet resent first", acc_at[15] - mark_cyc, 5);
    check(acc_at[16] - acc_at[15] == 5, "R8 paced send spacing", acc_at[16] - acc_at[15], 5);
    check(acc_at[17] - acc_at[16] == 5, "R8 paced send spacing last", acc_at[17] - acc_at[16], 5);
    respond(0, 'h400, 16);
    respond(0, 'h410, 16);
    respond(0, 'h420, 16);
    tick(1);
    check(done_n == 5, "R9 done after paced request", done_n, 5);
    tick(10);
    check(acc_n == 18, "R10 request while busy ignored", acc_n, 18);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    // zero length request
    issue(0, 'h500, 0);
    tick(5);
    check(busy == 1'b0, "R10 zero length ignored", busy, 0);
    check(acc_n == 18 && pkt_valid == 1'b0, "R10 zero length sends nothing", acc_n, 18);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule